// File: doc/BRIEF.md
# Routed Interrupt Controller

This controller collects a bank of hardware interrupt inputs and a bank of software-raised interrupt sources. It steers each source to one of a small set of level-sensitive CPU interrupt lines. Every source owns a 64-bit configuration word holding an enable flag, a recorded target thread number and a line selector. Software programs these words over a simple 64-bit register bus, and it raises or drops software sources by writing bitmasks to a set window and a clear window.

A hardware source is pending while its input is high. A software source is pending while its stored bit is set. Each output line is the OR of every enabled, pending source whose selector names that line. The thread field is stored and read back but does not affect delivery.

The bus side is a two-state machine. In `BUS_IDLE` the block accepts one access per cycle. A write completes in that cycle, and the transition `IDLE->RESP` is taken only for a read. `BUS_RESP` presents the captured read data for one cycle, and the transition `RESP->IDLE` always follows.

Top module: `pic_router`

## Requirements
- R1: The byte address splits into a region code in bits 11:10 (0 = configuration, 1 = pending read, 2 = pending set, 3 = pending clear) and a word index in bits 9:3. A configuration write to index i stores that source's word, and a configuration read of index i returns it.
- R2: In a stored configuration word, bit 31 is the enable flag, bits 30:8 are the thread number and bits 3:0 are the line selector. Bits 63:32 and 7:4 always read back as zero, whatever was written to them.
- R3: A source whose enable bit is 0 never drives an output, so writing an all-zero configuration word silences it.
- R4: Output line n (0 to 5) is high when at least one source is enabled, is pending and has selector value n. Selector values 6 to 15 drive no line.
- R5: When several sources share a line, the line stays high while any one of them still qualifies.
- R6: A write to the set window at word k sets the pending bit of every software source whose mask bit is 1. Mask bits that are 0 leave the pending bits unchanged.
- R7: A write to the clear window at word k clears the pending bit of every software source whose mask bit is 1. Mask bits that are 0 leave the pending bits unchanged.
- R8: A hardware source is pending exactly while its input is high. Set-window and clear-window writes aimed at hardware words have no effect.
- R9: Pending-window word k returns sources 64k to 64k+63, with bit j for source 64k+j. Hardware sources occupy indices 0 to 63, and software sources start at index 64.
- R10: After reset, every configuration word and every software pending bit is zero, and all output lines are low.
- R11: A read is accepted while `bus_ready` is high. In the next cycle `bus_rvalid` is high for exactly one cycle with the data and `bus_ready` is low. A change of configuration, pending state or hardware input reaches `irq_out` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hard_irq | input | 64 | Level inputs of the hardware sources |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 64 | Write data or mask |
| bus_ready | output | 1 | Block can accept an access |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| irq_out | output | 6 | Level-sensitive CPU interrupt lines |

## Verification
Random configuration words are used with selectors spanning all sixteen values, random enables and garbage in the reserved bits. These separate correct routing from an off-by-one line decode, from leakage of selectors 6 and above, and from reserved-bit leakage on readback. Random set and clear masks, mixed with toggling hardware inputs, distinguish write-one semantics from plain overwrite and confirm that hardware pending bits ignore the windows. Directed cases pin down the reset state, two sources OR-ed onto one line while one of them is removed, and writes into the hardware words of the set and clear windows.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int TID_W  = 23;
    localparam int LINE_W = 4;

    typedef struct packed {
        logic             en;
        logic [TID_W-1:0] tid;
        logic [LINE_W-1:0] line;
    } src_cfg_t;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_PEND = 2'd1,
        REG_SET  = 2'd2,
        REG_CLR  = 2'd3
    } region_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    function automatic src_cfg_t cfg_unpack(input logic [63:0] w);
        src_cfg_t c;
        c.en   = w[31];
        c.tid  = w[30:8];
        c.line = w[3:0];
        return c;
    endfunction

    function automatic logic [63:0] cfg_pack(input src_cfg_t c);
        return {32'd0, c.en, c.tid, 4'd0, c.line};
    endfunction
endpackage

// File: rtl/pic_cfg_store.sv
module pic_cfg_store
    import pic_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int IDX_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [63:0]            wr_word,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [63:0]            rd_word,
    output src_cfg_t [N_SRC-1:0]   cfg_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && (int'(wr_idx) < N_SRC)) begin
            cfg_q[wr_idx] <= cfg_unpack(wr_word);
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < N_SRC) begin
            rd_word = cfg_pack(cfg_q[rd_idx]);
        end
    end
endmodule

// File: rtl/pic_pending.sv
module pic_pending #(
    parameter int N_HARD = 64,
    parameter int N_SOFT = 64,
    parameter int IDX_W  = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_HARD-1:0]         hard_irq,
    input  logic                      set_en,
    input  logic                      clr_en,
    input  logic [IDX_W-1:0]          word_idx,
    input  logic [63:0]               mask,
    output logic [N_HARD+N_SOFT-1:0]  pend
);
    localparam int HARD_WORDS = N_HARD / 64;
    localparam int SOFT_WORDS = N_SOFT / 64;

    logic [N_SOFT-1:0] soft_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= '0;
        end else begin
            for (int w = 0; w < SOFT_WORDS; w++) begin
                if (int'(word_idx) == HARD_WORDS + w) begin
                    if (set_en) begin
                        soft_q[w*64 +: 64] <= soft_q[w*64 +: 64] | mask;
                    end else if (clr_en) begin
                        soft_q[w*64 +: 64] <= soft_q[w*64 +: 64] & ~mask;
                    end
                end
            end
        end
    end

    assign pend = {soft_q, hard_irq};
endmodule

// File: rtl/pic_route.sv
module pic_route
    import pic_pkg::*;
#(
    parameter int N_SRC   = 128,
    parameter int N_LINES = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  src_cfg_t [N_SRC-1:0] cfg_q,
    input  logic [N_SRC-1:0]     pend,
    output logic [N_LINES-1:0]   irq_q
);
    logic [N_LINES-1:0] irq_d;

    generate
        for (genvar n = 0; n < N_LINES; n++) begin : g_line
            logic [N_SRC-1:0] hit;
            for (genvar s = 0; s < N_SRC; s++) begin : g_src
                assign hit[s] = cfg_q[s].en && pend[s]
                                && (cfg_q[s].line == LINE_W'(n));
            end
            assign irq_d[n] = |hit;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/pic_router.sv
module pic_router
    import pic_pkg::*;
#(
    parameter int N_HARD  = 64,
    parameter int N_SOFT  = 64,
    parameter int N_LINES = 6,
    parameter int ADDR_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_HARD-1:0]   hard_irq,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [63:0]         bus_wdata,
    output logic                bus_ready,
    output logic                bus_rvalid,
    output logic [63:0]         bus_rdata,
    output logic [N_LINES-1:0]  irq_out
);
    localparam int N_SRC   = N_HARD + N_SOFT;
    localparam int IDX_W   = ADDR_W - 5;
    localparam int N_WORDS = N_SRC / 64;

    bus_state_e state_q, state_d;
    region_e    region;
    logic [IDX_W-1:0] idx;
    logic       accept, wr_acc, rd_acc;
    logic [63:0] cfg_rd, pend_rd, rdata_d;
    src_cfg_t [N_SRC-1:0] cfg_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] en_vec;

    assign region = region_e'(bus_addr[ADDR_W-1 -: 2]);
    assign idx    = bus_addr[ADDR_W-3:3];
    assign accept = bus_req && (state_q == BUS_IDLE);
    assign wr_acc = accept && bus_we;
    assign rd_acc = accept && !bus_we;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_acc) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_ready  = (state_q == BUS_IDLE);
        bus_rvalid = (state_q == BUS_RESP);
    end

    pic_cfg_store #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_acc && region == REG_CFG),
        .wr_idx  (idx),
        .wr_word (bus_wdata),
        .rd_idx  (idx),
        .rd_word (cfg_rd),
        .cfg_q   (cfg_q)
    );

    pic_pending #(.N_HARD(N_HARD), .N_SOFT(N_SOFT), .IDX_W(IDX_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .hard_irq (hard_irq),
        .set_en   (wr_acc && region == REG_SET),
        .clr_en   (wr_acc && region == REG_CLR),
        .word_idx (idx),
        .mask     (bus_wdata),
        .pend     (pend)
    );

    pic_route #(.N_SRC(N_SRC), .N_LINES(N_LINES)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_q (cfg_q),
        .pend  (pend),
        .irq_q (irq_out)
    );

    always_comb begin
        pend_rd = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (int'(idx) == k) pend_rd = pend[k*64 +: 64];
        end
    end

    always_comb begin
        unique case (region)
            REG_CFG:  rdata_d = cfg_rd;
            REG_PEND: rdata_d = pend_rd;
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rdata_d;
    end

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_en
            assign en_vec[s] = cfg_q[s].en;
        end
    endgenerate
endmodule

// File: rtl/pic_router_chk.sv
module pic_router_chk #(
    parameter int N_HARD  = 64,
    parameter int N_SOFT  = 64,
    parameter int N_LINES = 6,
    parameter int ADDR_W  = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [63:0]                bus_wdata,
    input logic                       bus_ready,
    input logic                       bus_rvalid,
    input logic [63:0]                bus_rdata,
    input logic [N_LINES-1:0]         irq_out,
    input logic [N_HARD+N_SOFT-1:0]   en_vec,
    input logic [N_HARD+N_SOFT-1:0]   pend
);
    localparam int HW = N_HARD / 64;

    logic acc_wr, acc_rd;
    assign acc_wr = bus_req && bus_ready && bus_we;
    assign acc_rd = bus_req && bus_ready && !bus_we;

    a_r11_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> (bus_rvalid && !bus_ready));

    a_r11_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr[ADDR_W-1 -: 2] == 2'd0)
        |=> (bus_rdata[63:32] == 32'd0 && bus_rdata[7:4] == 4'd0));

    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |=> (irq_out == '0));

    a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && bus_addr[ADDR_W-1 -: 2] == 2'd2
         && int'(bus_addr[ADDR_W-3:3]) == HW)
        |=> ((pend[N_HARD +: 64] & $past(bus_wdata)) == $past(bus_wdata)));

    a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && bus_addr[ADDR_W-1 -: 2] == 2'd3
         && int'(bus_addr[ADDR_W-3:3]) == HW)
        |=> ((pend[N_HARD +: 64] & $past(bus_wdata)) == 64'd0));
endmodule

bind pic_router pic_router_chk #(
    .N_HARD(N_HARD), .N_SOFT(N_SOFT), .N_LINES(N_LINES), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .irq_out    (irq_out),
    .en_vec     (en_vec),
    .pend       (pend)
);

// File: tb/tb_pic_router.sv
`timescale 1ns/1ps
module tb_pic_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] hard_irq = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [63:0] bus_rdata;
    logic [5:0]  irq_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] cfg_m [128];
    logic [63:0] soft_m = '0;

    localparam logic [63:0] CFG_KEEP = 64'h0000_0000_FFFF_FF0F;

    always #4 clk = ~clk;

    pic_router dut (
        .clk(clk), .rst_n(rst_n), .hard_irq(hard_irq),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [5:0] exp_irq();
        logic [5:0] r = '0;
        for (int s = 0; s < 128; s++) begin
            logic p;
            p = (s < 64) ? hard_irq[s] : soft_m[s-64];
            if (cfg_m[s][31] && p && cfg_m[s][3:0] < 4'd6)
                r[cfg_m[s][3:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] reg_sel, input int word,
                             input logic [63:0] data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = {reg_sel, 7'(word), 3'b000}; bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] reg_sel, input int word,
                            output logic [63:0] data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0;
        bus_addr = {reg_sel, 7'(word), 3'b000};
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        n_chk++;
        if (!bus_rvalid || bus_ready) begin
            n_fail++;
            $display("FAIL R11 rvalid=%b ready=%b expected 1/0",
                     bus_rvalid, bus_ready);
        end
        data = bus_rdata;
        @(posedge clk);
    endtask

    task automatic wr_cfg(input int s, input logic [63:0] w);
        bus_write(2'd0, s, w);
        cfg_m[s] = w & CFG_KEEP;
    endtask

    task automatic settle_irq(input string req);
        @(posedge clk);
        @(negedge clk);
        check(req, {58'd0, irq_out}, {58'd0, exp_irq()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        for (int s = 0; s < 128; s++) cfg_m[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        check("R10 irq", {58'd0, irq_out}, 64'd0);
        bus_read(2'd0, 0, rd);   check("R10 cfg0", rd, 64'd0);
        bus_read(2'd0, 127, rd); check("R10 cfg127", rd, 64'd0);
        bus_read(2'd1, 1, rd);   check("R10 soft pend", rd, 64'd0);

        // R1 R2: layout and reserved bits
        wr_cfg(70, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(2'd0, 70, rd); check("R2 reserved", rd, 64'h0000_0000_FFFF_FF0F);
        wr_cfg(5, 64'h1234_5678_8000_0A42);
        bus_read(2'd0, 5, rd);  check("R1 cfg word", rd, 64'h0000_0000_8000_0A02);
        wr_cfg(70, 64'd0);
        wr_cfg(5, 64'd0);

        // R8: hard pending follows level, windows cannot touch it
        hard_irq = 64'h00F0_0000_0000_0001;
        bus_write(2'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(2'd1, 0, rd); check("R8 hard set ignored", rd, hard_irq);
        bus_write(2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(2'd1, 0, rd); check("R8 hard clr ignored", rd, hard_irq);

        // R5 / R4: two sources on line 2; line field 6 drives nothing
        wr_cfg(0, 64'h8000_0002);
        wr_cfg(64, 64'h8000_0002);
        bus_write(2'd2, 1, 64'h1);
        soft_m = 64'h1;
        settle_irq("R4 line2");
        check("R5 both", {58'd0, irq_out}, 64'h4);
        hard_irq[0] = 1'b0;
        settle_irq("R5 one left");
        check("R5 still high", {58'd0, irq_out}, 64'h4);
        wr_cfg(64, 64'h8000_0006);
        settle_irq("R4 line6 none");
        check("R4 line6 none", {58'd0, irq_out}, 64'h0);
        // R3: all-zero config silences
        wr_cfg(64, 64'h8000_0001);
        settle_irq("R3 enabled");
        wr_cfg(64, 64'd0);
        settle_irq("R3 zero word");
        check("R3 silent", {58'd0, irq_out}, 64'h0);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0, 1: begin
                    int s;
                    logic [63:0] w;
                    s = int'($urandom % 128);
                    w = {$urandom, $urandom};
                    w[31] = ($urandom % 4) != 0;
                    wr_cfg(s, w);
                    if (it % 8 == 0) begin
                        bus_read(2'd0, s, rd);
                        check("R1 cfg readback", rd, cfg_m[s]);
                    end
                end
                2: begin
                    logic [63:0] m;
                    m = {$urandom, $urandom} & {$urandom, $urandom};
                    bus_write(2'd2, 1, m);
                    soft_m = soft_m | m;
                    bus_read(2'd1, 1, rd);
                    check("R6 set window", rd, soft_m);
                end
                3: begin
                    logic [63:0] m;
                    m = {$urandom, $urandom} & {$urandom, $urandom};
                    bus_write(2'd3, 1, m);
                    soft_m = soft_m & ~m;
                    bus_read(2'd1, 1, rd);
                    check("R7 clear window", rd, soft_m);
                end
                4: begin
                    @(negedge clk);
                    hard_irq = {$urandom, $urandom} & {$urandom, $urandom};
                    bus_read(2'd1, 0, rd);
                    check("R9 hard word", rd, hard_irq);
                end
                default: begin
                    bus_read(2'd1, 1, rd);
                    check("R9 soft word", rd, soft_m);
                end
            endcase
            settle_irq("R4 route");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule